// File: doc/BRIEF.md
# Clipped-Rule Aggregator with Centre-of-Gravity Output

This block turns the fired strengths of a bank of fuzzy rules into a single crisp output level. Each rule has a strength (its weight) and an output membership shape given as a grade at each of 16 discrete output levels. The block limits every rule's shape to that rule's strength, merges all rules by keeping the largest limited grade at each level, and reduces the merged shape to its centre of gravity.

Work is spread over four accumulate cycles. In each cycle four lanes handle four levels that lie a quarter of the range apart, starting from the top level of each quarter and walking downward. Each lane has its own maximum tree across the rules. The weighted sum and the plain sum of the merged grades build up over those four cycles. A final cycle divides one by the other. A one-cycle done pulse marks a fresh result. The weight and shape inputs are read live and must stay stable while their levels are being sampled.

Top module: `fuzzy_cog_defuzz`

## Requirements
- R1: For rule r at level m the contribution is min(weight r, grade of rule r at level m). Weights and grades are 4-bit values packed with rule r's weight at bits [4r+3:4r] and rule r's grade at level m at bits [4(16r+m)+3 : 4(16r+m)].
- R2: The merged grade O(m) is the maximum of the contributions of all rules at level m.
- R3: The result is floor(sum of m·O(m) / sum of O(m)) over m = 0..15, given as a 4-bit level index.
- R4: When the sum of O(m) is zero, the result is 0 and nofire is 1. Otherwise nofire is 0.
- R5: start is accepted when sampled high at a rising edge while the block is idle. done is then high for exactly one cycle, after the fifth rising edge that follows the accepting edge.
- R6: start pulses while a computation is in flight are ignored. The done timing of the current run is unchanged, and no extra done follows.
- R7: result and nofire keep their values from one done until the next done, whatever the weight and grade inputs do in between.
- R8: The first accumulate edge after acceptance samples levels 15, 11, 7 and 3. Each later edge samples the next level down in each quarter, ending with 12, 8, 4 and 0. A grade that changes after its level has been sampled does not alter the result.
- R9: During and after reset, done, nofire and result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation when idle |
| weight | input | NRULES*GW | Packed rule strengths |
| conseq | input | NRULES*NLEV*GW | Packed rule output grades per level |
| result | output | log2(NLEV) | Crisp output level index |
| nofire | output | 1 | No rule produced any grade |
| done | output | 1 | One-cycle pulse when result is updated |

## Verification
Small hand-built patterns separate the operators. A clipped single rule gives a different centroid than an unclipped one. Two overlapping rules give a different answer under a maximum than under a sum. Lone grades at level 0 and level 15 pin the ends of the range and separate an empty shape from one that sits only at level 0. Random weight and grade sets, some with every weight zero, are compared with an arithmetic centroid model. Timed input changes in the middle of a run tell apart levels that were already sampled from levels still to come.

// File: rtl/fuzzy_cog_defuzz.sv
module fuzzy_cog_defuzz #(
  parameter int NRULES = 16,
  parameter int GW     = 4,
  parameter int NLEV   = 16,
  parameter int LANES  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [NRULES*GW-1:0]        weight,
  input  logic [NRULES*NLEV*GW-1:0]   conseq,
  output logic [$clog2(NLEV)-1:0]     result,
  output logic                        nofire,
  output logic                        done
);
  localparam int STEPS  = NLEV / LANES;
  localparam int SW     = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int LW     = $clog2(NLEV);
  localparam int MAXG   = (1 << GW) - 1;
  localparam int NUMMAX = MAXG * NLEV * (NLEV - 1) / 2;
  localparam int NUMW   = $clog2(NUMMAX + 1);
  localparam int DENW   = $clog2(MAXG * NLEV + 1);

  logic            busy, div_go;
  logic [SW-1:0]   step;
  logic [NUMW-1:0] num, num_add;
  logic [DENW-1:0] den, den_add;

  always_comb begin
    logic [LW-1:0] lv;
    logic [GW-1:0] mx, cv, wv, clip;
    num_add = '0;
    den_add = '0;
    for (int j = 0; j < LANES; j++) begin
      lv = LW'((j + 1) * STEPS - 1) - LW'(step);
      mx = '0;
      for (int r = 0; r < NRULES; r++) begin
        cv   = conseq[(r*NLEV + int'(lv))*GW +: GW];
        wv   = weight[r*GW +: GW];
        clip = (wv < cv) ? wv : cv;
        if (clip > mx) mx = clip;
      end
      num_add = num_add + NUMW'(lv) * NUMW'(mx);
      den_add = den_add + DENW'(mx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      div_go <= 1'b0;
      step   <= '0;
      num    <= '0;
      den    <= '0;
      result <= '0;
      nofire <= 1'b0;
      done   <= 1'b0;
    end else begin
      done   <= 1'b0;
      div_go <= 1'b0;
      if (!busy && !div_go && start) begin
        busy <= 1'b1;
        step <= '0;
        num  <= '0;
        den  <= '0;
      end else if (busy) begin
        num  <= num + num_add;
        den  <= den + den_add;
        step <= step + 1'b1;
        if (step == SW'(STEPS - 1)) begin
          busy   <= 1'b0;
          div_go <= 1'b1;
        end
      end
      if (div_go) begin
        result <= (den == '0) ? '0 : LW'(num / NUMW'(den));
        nofire <= (den == '0);
        done   <= 1'b1;
      end
    end
  end

  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: an idle start begins the accumulate phase at the first step
  a_r5_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !div_go) |=> (busy && step == '0));
  // R5: the last accumulate step hands over to the divide stage
  a_r5_handover: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step == SW'(STEPS - 1)) |=> (!busy && div_go));
  // R6: a start during the run does not restart the step counter
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step != SW'(STEPS - 1)) |=> (busy && step == $past(step) + 1'b1));
  // R4: an empty shape reports level 0
  a_r4_nofire_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && nofire) |-> (result == '0));
  // R7: outputs hold outside the divide stage
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !div_go |=> ($stable(result) && $stable(nofire)));
  // R3: the denominator never shrinks while accumulating
  a_r3_den_grows: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (den >= $past(den)));
endmodule

// File: tb/sim_fuzzy_cog_defuzz.sv
module sim_fuzzy_cog_defuzz;
  localparam int NR = 16, GW = 4, NL = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start;
  logic [NR*GW-1:0]    wv;
  logic [NR*NL*GW-1:0] cv;
  logic [3:0] result;
  logic nofire, done;
  logic [3:0] w [NR];
  logic [3:0] c [NR][NL];
  int checks = 0, errors = 0;

  fuzzy_cog_defuzz u0 (.clk(clk), .rst_n(rst_n), .start(start), .weight(wv),
    .conseq(cv), .result(result), .nofire(nofire), .done(done));

  always_comb begin
    for (int r = 0; r < NR; r++) begin
      wv[r*GW +: GW] = w[r];
      for (int m = 0; m < NL; m++) cv[(r*NL+m)*GW +: GW] = c[r][m];
    end
  end

  function automatic logic [4:0] model();
    int num, den, o, v;
    num = 0; den = 0;
    for (int m = 0; m < NL; m++) begin
      o = 0;
      for (int r = 0; r < NR; r++) begin
        v = (w[r] < c[r][m]) ? int'(w[r]) : int'(c[r][m]);
        if (v > o) o = v;
      end
      num += m * o; den += o;
    end
    if (den == 0) return 5'b10000;
    return {1'b0, 4'(num / den)};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    for (int r = 0; r < NR; r++) begin
      w[r] = '0;
      for (int m = 0; m < NL; m++) c[r][m] = '0;
    end
  endtask

  task automatic launch();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run(input string tag);
    logic [4:0] e;
    e = model();
    launch();
    repeat (4) @(negedge clk);
    chk(done == 1'b0, "R5 early", done, 0);
    @(negedge clk);
    chk(done == 1'b1, "R5 done", done, 1);
    chk(result == e[3:0], tag, result, e[3:0]);
    chk(nofire == e[4], "R4 nofire", nofire, e[4]);
    @(negedge clk);
    chk(done == 1'b0, "R5 pulse", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] e;
    logic [3:0] held_r;
    logic held_n;
    rst_n = 1'b0; start = 1'b0; clr();
    repeat (3) @(negedge clk);
    chk(done == 0, "R9 done", done, 0);
    chk(nofire == 0, "R9 nofire", nofire, 0);
    chk(result == 0, "R9 result", result, 0);
    rst_n = 1'b1;

    run("R4 empty");
    chk(nofire == 1 && result == 0, "R4 empty flag", {nofire, result}, 16);

    for (int r = 0; r < NR; r++) begin
      w[r] = 15;
      for (int m = 0; m < NL; m++) c[r][m] = 15;
    end
    run("R3 full");
    chk(result == 7, "R3 full value", result, 7);

    clr(); w[0] = 3; c[0][15] = 15; c[0][0] = 15; w[1] = 15; c[1][0] = 15;
    run("R1 clip");
    chk(result == 2, "R1 clip value", result, 2);

    clr(); w[0] = 15; w[1] = 15; c[0][4] = 9; c[1][4] = 6; c[1][12] = 9;
    run("R2 max");
    chk(result == 8, "R2 max value", result, 8);

    clr(); w[5] = 15; c[5][15] = 1;
    run("R3 top");
    chk(result == 15, "R3 top value", result, 15);

    clr(); w[9] = 2; c[9][0] = 11;
    run("R4 level0");
    chk(result == 0 && nofire == 0, "R4 level0 value", {nofire, result}, 0);

    for (int k = 0; k < 300; k++) begin
      bit sparse;
      sparse = ($urandom % 8) == 0;
      for (int r = 0; r < NR; r++) begin
        w[r] = sparse ? 4'd0 : 4'($urandom);
        for (int m = 0; m < NL; m++) c[r][m] = 4'($urandom);
      end
      run("R3 random");
    end

    // R6: a start in mid-run is ignored
    clr(); w[2] = 15; c[2][6] = 7; c[2][10] = 7;
    e = model();
    launch();
    @(negedge clk); @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk);
    chk(done == 0, "R6 early", done, 0);
    @(negedge clk);
    chk(done == 1, "R6 done timing", done, 1);
    chk(result == e[3:0], "R6 result", result, e[3:0]);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      chk(done == 0, "R6 no extra done", done, 0);
    end

    // R7: outputs hold while inputs move without start
    held_r = result; held_n = nofire;
    for (int k = 0; k < 8; k++) begin
      w[k] = 4'($urandom); c[k][k] = 4'($urandom);
      @(negedge clk);
    end
    chk(result == held_r, "R7 result hold", result, held_r);
    chk(nofire == held_n, "R7 nofire hold", nofire, held_n);

    // R8: level 15 is sampled on the first accumulate edge, level 12 on the last
    clr(); w[0] = 15; c[0][15] = 10; c[0][13] = 10;
    c[0][12] = 10;
    e = model();
    c[0][12] = 0;
    launch();
    @(negedge clk);
    c[0][15] = 0; c[0][12] = 10;
    repeat (3) @(negedge clk);
    chk(done == 0, "R8 early", done, 0);
    @(negedge clk);
    chk(done == 1, "R8 done", done, 1);
    chk(result == e[3:0], "R8 order", result, e[3:0]);
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule